// File: doc/BRIEF.md
# Double-Sampling Five-Stage Pipeline with Timing-Error Recovery

This block is the control and data skeleton of a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. Every stage register is built as a pair of elements. A main register captures the stage input at the clock edge. A second register models a capture taken slightly later, when the input has had time to settle. The later sample is correct by construction. When the two disagree, the stage reports a timing error. The stage then reloads its main register from the later sample and holds its instruction for one cycle. The stage downstream receives an empty slot. Every instruction upstream of the failing stage is discarded, and fetch restarts just after the failing instruction, the same way a mispredicted branch is handled.

A late-arriving input is modelled by a per-stage XOR mask. The mask corrupts only what the main register sees. When the stage advances a valid slot and the mask is nonzero, the result is an error one cycle later. Committed results leave through a final stabilising register after writeback. An instruction that fails in writeback is therefore never committed with bad data. A running counter adds up every stage error seen.

Fetch produces the word `{pc[7:0],pc[15:8]} ^ 16'h5A3C` for each PC. Stage k (1..4) turns its upstream word d into `rotl1(d) + k*16'h0101`. The committed word is the result after stage 4.

Top module: `ds_pipe`

## Requirements
- R1: While reset is asserted, all stage valid bits, `commit_valid` and `err_count` are 0 and `fetch_pc` is 0.
- R2: With no injected masks, commits appear in PC order 0,1,2,... Each `commit_data` equals the four stage transforms applied to the fetch word of its PC.
- R3: If a stage advances a valid slot while its mask is nonzero, its bit of `err_vec` (bit 0 = fetch ... bit 4 = writeback) is 1 in the following cycle. With a zero mask the bit stays 0.
- R4: In the cycle after an error, the failing stage still holds its instruction, now with the corrected word, and reports no error.
- R5: In the cycle after an error in stage e < 4, stage e+1 holds an empty (invalid) slot.
- R6: In the cycle after an error in stage e, every stage below e is invalid. `fetch_pc` is then one past the failing instruction's PC, so the commit stream has no gap and no repeat.
- R7: When several stages fail in one cycle, `flush_stage` names the highest-numbered (oldest) failing stage, and only that stage is restored.
- R8: An instruction that fails in writeback is not committed in the next cycle (`commit_valid` is 0).
- R9: `err_count` grows each cycle by the number of set bits in `err_vec` and holds when no bit is set.
- R10: A nonzero mask on a stage whose incoming slot is invalid causes no error and no count change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| late_mask | input | 80 | Per-stage late-data XOR mask, stage k in bits [16k+15:16k] |
| stage_v | output | 5 | Valid bit of each stage register |
| err_vec | output | 5 | Per-stage timing-error flags |
| flush_valid | output | 1 | A flush/restore is taking place this cycle |
| flush_stage | output | 3 | Index of the stage that sets the flush point |
| fetch_pc | output | 16 | PC fetched at the next edge |
| commit_valid | output | 1 | A result leaves the stabilising register |
| commit_pc | output | 16 | PC of the committed instruction |
| commit_data | output | 16 | Committed word |
| err_count | output | 16 | Running count of stage errors |

## Verification
The in-RTL properties assume that a mask is meaningful only while its stage advances a valid slot. They also assume that the counter cannot wrap within a single step and that the PC space does not wrap during a run. The stimulus drives masks only between edges and never issues more than a few thousand instructions. The random phase applies nonzero masks to any subset of stages in any cycle, including stages that are empty or being killed. The directed cases fix a full pipeline before injecting, so that the expected valid pattern and restart PC follow directly from the requirements.

// File: rtl/ds_pkg.sv
package ds_pkg;
  localparam int N_STAGES = 5;
  localparam int PC_W     = 16;
  localparam int DATA_W   = 16;
  localparam int SEL_W    = $clog2(N_STAGES);

  typedef struct packed {
    logic              v;
    logic [PC_W-1:0]   pc;
    logic [DATA_W-1:0] data;
  } slot_t;

  typedef enum logic [1:0] {
    CTL_ADV     = 2'd0,
    CTL_RESTORE = 2'd1,
    CTL_KILL    = 2'd2
  } ctl_e;

  // word produced by fetch for a given PC
  function automatic logic [DATA_W-1:0] fetch_word(input logic [PC_W-1:0] pc);
    logic [DATA_W-1:0] w;
    w = DATA_W'(pc);
    return {w[DATA_W/2-1:0], w[DATA_W-1:DATA_W/2]} ^ DATA_W'(16'h5A3C);
  endfunction

  // work done by stage idx on its upstream word
  function automatic logic [DATA_W-1:0] stage_work(input int unsigned idx,
                                                   input logic [DATA_W-1:0] d);
    return {d[DATA_W-2:0], d[DATA_W-1]} + DATA_W'(idx * 32'h0101);
  endfunction

  // number of stage errors in one cycle
  function automatic logic [SEL_W:0] err_weight(input logic [N_STAGES-1:0] e);
    logic [SEL_W:0] n;
    n = '0;
    for (int i = 0; i < N_STAGES; i++) n = n + (SEL_W+1)'(e[i]);
    return n;
  endfunction
endpackage

// File: rtl/ds_stage.sv
module ds_stage
  import ds_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  slot_t             settled,
  input  logic [DATA_W-1:0] late,
  input  ctl_e              ctl,
  output slot_t             q,
  output logic              err
);
  slot_t shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= '0;
      shadow <= '0;
    end else begin
      case (ctl)
        CTL_ADV: begin
          q      <= '{v: settled.v, pc: settled.pc, data: settled.data ^ late};
          shadow <= settled;
        end
        CTL_RESTORE: q <= shadow;
        default: begin
          q      <= '0;
          shadow <= '0;
        end
      endcase
    end
  end

  assign err = q.v && (q.data != shadow.data);

  // R3
  late_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == CTL_ADV && settled.v && late != '0) |=> err);
  // R3
  clean_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == CTL_ADV && late == '0) |=> !err);
  // R10
  empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == CTL_ADV && !settled.v) |=> !err);
  // R4
  restore_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == CTL_RESTORE) |=> (q == $past(shadow)) && !err);
endmodule

// File: rtl/ds_flush.sv
module ds_flush
  import ds_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_STAGES-1:0] err_vec,
  output logic                any,
  output logic [SEL_W-1:0]    sel,
  output ctl_e                ctl [N_STAGES]
);
  logic [N_STAGES-1:0] rest_bits;

  always_comb begin
    any = |err_vec;
    sel = '0;
    for (int s = 0; s < N_STAGES; s++)
      if (err_vec[s]) sel = SEL_W'(s);
  end

  for (genvar s = 0; s < N_STAGES; s++) begin : g_ctl
    always_comb begin
      if (!any)                                      ctl[s] = CTL_ADV;
      else if (int'(sel) == s)                       ctl[s] = CTL_RESTORE;
      else if (s < int'(sel) || s == int'(sel) + 1)  ctl[s] = CTL_KILL;
      else                                           ctl[s] = CTL_ADV;
    end
    assign rest_bits[s] = (ctl[s] == CTL_RESTORE);
  end

  // R7
  oldest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (err_vec[sel] && ((err_vec >> sel) == N_STAGES'(1))));
  // R7
  one_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rest_bits) == (any ? 1 : 0));
endmodule

// File: rtl/ds_evcount.sv
module ds_evcount
  import ds_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_STAGES-1:0] err_vec,
  output logic [CNT_W-1:0]    count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + CNT_W'(err_weight(err_vec));
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vec == '0) |=> $stable(count));
  // R9
  event_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vec != '0) |=> (count != $past(count)));
endmodule

// File: rtl/ds_pipe.sv
module ds_pipe
  import ds_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_STAGES*DATA_W-1:0] late_mask,
  output logic [N_STAGES-1:0]        stage_v,
  output logic [N_STAGES-1:0]        err_vec,
  output logic                       flush_valid,
  output logic [SEL_W-1:0]           flush_stage,
  output logic [PC_W-1:0]            fetch_pc,
  output logic                       commit_valid,
  output logic [PC_W-1:0]            commit_pc,
  output logic [DATA_W-1:0]          commit_data,
  output logic [CNT_W-1:0]           err_count
);
  localparam int LAST = N_STAGES - 1;

  slot_t            q       [N_STAGES];
  slot_t            settled [N_STAGES];
  ctl_e             ctl     [N_STAGES];
  logic [N_STAGES-1:0] err;
  logic             fl_any;
  logic [SEL_W-1:0] fl_sel;
  logic [PC_W-1:0]  fpc;
  slot_t            commit_q;

  always_comb settled[0] = '{v: 1'b1, pc: fpc, data: fetch_word(fpc)};

  for (genvar s = 1; s < N_STAGES; s++) begin : g_in
    always_comb settled[s] = '{v: q[s-1].v, pc: q[s-1].pc,
                               data: stage_work(s, q[s-1].data)};
  end

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    ds_stage u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .settled (settled[s]),
      .late    (late_mask[s*DATA_W +: DATA_W]),
      .ctl     (ctl[s]),
      .q       (q[s]),
      .err     (err[s])
    );
    assign stage_v[s] = q[s].v;
  end

  ds_flush u_flush (
    .clk     (clk),
    .rst_n   (rst_n),
    .err_vec (err),
    .any     (fl_any),
    .sel     (fl_sel),
    .ctl     (ctl)
  );

  ds_evcount #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .err_vec (err),
    .count   (err_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fpc <= '0;
    else if (fl_any) fpc <= q[fl_sel].pc + 1'b1;
    else             fpc <= fpc + 1'b1;
  end

  // stabilising register after writeback
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       commit_q <= '0;
    else if (q[LAST].v && !err[LAST]) commit_q <= q[LAST];
    else                              commit_q <= '0;
  end

  assign err_vec      = err;
  assign flush_valid  = fl_any;
  assign flush_stage  = fl_sel;
  assign fetch_pc     = fpc;
  assign commit_valid = commit_q.v;
  assign commit_pc    = commit_q.pc;
  assign commit_data  = commit_q.data;

  // checker state: last committed PC
  logic [PC_W-1:0] last_pc;
  logic            seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pc <= '0;
      seen    <= 1'b0;
    end else if (commit_q.v) begin
      last_pc <= commit_q.pc;
      seen    <= 1'b1;
    end
  end

  // R2
  commit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && seen) |-> (commit_pc == last_pc + 1'b1));
  // R8
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err[LAST] |=> !commit_valid);

  for (genvar s = 0; s < N_STAGES; s++) begin : g_chk
    localparam logic [N_STAGES-1:0] LOWM = N_STAGES'((1 << s) - 1);
    if (s < LAST) begin : g_bub
      // R5
      bubble_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_any && fl_sel == SEL_W'(s)) |=> !q[s+1].v);
    end
    // R6
    flush_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_any && fl_sel == SEL_W'(s)) |=> ((stage_v & LOWM) == '0));
  end
endmodule

// File: tb/tb_ds_pipe.sv
module tb_ds_pipe;
  localparam int NS = 5;
  localparam int DW = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NS*DW-1:0]  late_mask = '0;
  logic [NS-1:0]     stage_v, err_vec;
  logic              flush_valid, commit_valid;
  logic [2:0]        flush_stage;
  logic [15:0]       fetch_pc, commit_pc, commit_data, err_count;

  int checks = 0, errors = 0;
  bit sb_on = 1'b0, done = 1'b0;
  int unsigned exp_pc = 0, exp_cnt = 0;

  ds_pipe dut (
    .clk(clk), .rst_n(rst_n), .late_mask(late_mask), .stage_v(stage_v),
    .err_vec(err_vec), .flush_valid(flush_valid), .flush_stage(flush_stage),
    .fetch_pc(fetch_pc), .commit_valid(commit_valid), .commit_pc(commit_pc),
    .commit_data(commit_data), .err_count(err_count)
  );

  always #2 clk = ~clk;

  function automatic logic [15:0] model_word(input logic [15:0] pc);
    logic [15:0] d;
    d = {pc[7:0], pc[15:8]} ^ 16'h5A3C;
    for (int k = 1; k <= 4; k++) d = ((d << 1) | (d >> 15)) + 16'(k * 257);
    return d;
  endfunction

  function automatic int unsigned ones(input logic [NS-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < NS; i++) n += v[i];
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard: commit stream (R2, R6) and error counter (R9)
  always @(negedge clk) begin
    if (sb_on) begin
      if (commit_valid) begin
        check(commit_pc == 16'(exp_pc), "R2", "commit pc", commit_pc, exp_pc);
        check(commit_data == model_word(16'(exp_pc)), "R2", "commit data",
              commit_data, model_word(16'(exp_pc)));
        exp_pc++;
      end
      check(err_count == 16'(exp_cnt), "R9", "err count", err_count, exp_cnt);
      exp_cnt += ones(err_vec);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // full pipeline, inject masks, check the flush pattern
  task automatic directed(input logic [NS-1:0] which, input int oldest);
    logic [NS*DW-1:0] m;
    logic [NS-1:0] ev;
    logic [15:0] base;
    idle(10);
    check(stage_v == 5'b11111, "R2", "pipeline full", stage_v, 5'b11111);
    m = '0;
    for (int s = 0; s < NS; s++) if (which[s]) m[s*DW +: DW] = 16'h0100 << s;
    late_mask = m;
    @(negedge clk);
    late_mask = '0;
    base = commit_pc;
    check(err_vec == which, "R3", "err_vec", err_vec, which);
    check(flush_valid == 1'b1, "R6", "flush_valid", flush_valid, 1);
    check(flush_stage == 3'(oldest), "R7", "flush_stage", flush_stage, oldest);
    @(negedge clk);
    for (int s = 0; s < NS; s++) ev[s] = (s > oldest + 1) || (s == oldest);
    check(stage_v == ev, "R5", "stage_v after error", stage_v, ev);
    check(fetch_pc == base + 16'(6 - oldest), "R6", "restart pc", fetch_pc,
          base + 16'(6 - oldest));
    check(err_vec == '0, "R4", "restored stage clean", err_vec, 0);
    if (oldest == 4)
      check(commit_valid == 1'b0, "R8", "no commit after wb error", commit_valid, 0);
  endtask

  initial begin
    int unsigned r;
    logic [NS*DW-1:0] m;
    r = $urandom(32'd20240607);
    idle(3);
    check(stage_v == '0, "R1", "reset stage_v", stage_v, 0);
    check(commit_valid == 1'b0, "R1", "reset commit_valid", commit_valid, 0);
    check(err_count == '0, "R1", "reset err_count", err_count, 0);
    check(fetch_pc == '0, "R1", "reset fetch_pc", fetch_pc, 0);
    rst_n = 1'b1;
    sb_on = 1'b1;
    // R10: stage 3 input is empty for the first three edges
    late_mask[3*DW +: DW] = 16'hFFFF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(err_vec == '0, "R10", "mask on empty slot", err_vec, 0);
    end
    late_mask = '0;
    @(negedge clk);
    check(err_count == '0, "R10", "count untouched", err_count, 0);
    idle(12);
    check(exp_pc >= 8, "R2", "clean progress", exp_pc, 8);

    directed(5'b00100, 2);
    directed(5'b00001, 0);
    directed(5'b10000, 4);
    directed(5'b01000, 3);
    directed(5'b01010, 3);
    directed(5'b10101, 4);

    // random phase
    for (int c = 0; c < 3000; c++) begin
      m = '0;
      for (int s = 0; s < NS; s++)
        if ($urandom_range(11) == 0) m[s*DW +: DW] = 16'(($urandom() % 16'hFFFF) + 1);
      late_mask = m;
      @(negedge clk);
    end
    late_mask = '0;
    idle(20);
    check(exp_pc >= 1000, "R6", "random progress", exp_pc, 1000);
    check(stage_v == 5'b11111, "R6", "refilled", stage_v, 5'b11111);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule